// File: doc/BRIEF.md
# Streaming Binary Systolic Correlator

This block computes a sliding correlation between a stream of 1-bit samples and a 1-bit reference kernel of `KLEN` taps. Each bit marks a cell as inside (1) or outside (0) a shape, so the product of two bits is a plain AND and no multiplier is needed. The result is the direct sum of these products over the window, with no transform step.

A setup phase comes first: the kernel is shifted in one bit per cycle through a load port. After setup, every accepted sample is broadcast to a linear chain of processing elements. Each element ANDs the sample with its own kernel tap and adds the product to the partial sum passed on by its neighbour, and it keeps that partial sum in its own register. Once the window has filled, the last element produces one finished correlation per accepted sample.

The input stream may pause at any time without losing work. A synchronous reset clears all partial sums but leaves the loaded kernel in place.

Top module: `binary_systolic_correlator`

## Requirements
- R1: Each valid result equals the number of positions `i` (0 ≤ i < KLEN) where the kernel bit loaded i-th (the first loaded bit is i = 0) and the accepted sample i places before the newest one are both 1. The first loaded kernel bit therefore pairs with the newest sample, and the last loaded bit pairs with the oldest sample in the window.
- R2: After the window has filled, every accepted sample (`inVal` high with `kernLoad` low at a clock edge) produces exactly one result. That result is on `outData`, with `outValid` high, for the single cycle after that edge.
- R3: After a reset or a kernel load, `outValid` stays low for the first KLEN-1 accepted samples. It first rises after the KLEN-th accepted sample.
- R4: A cycle with `inVal` low changes no partial sum. `outValid` is low in the cycle that follows it and `outData` holds its value. A stream that pauses and resumes gives the same results as the same stream sent without a pause.
- R5: Each cycle with `kernLoad` high shifts `kernBit` into the kernel. Input samples in that cycle are ignored. The cycle also clears all partial sums, drives `outValid` low and `outData` to zero, and restarts the fill count.
- R6: A synchronous reset (`rst` high at a clock edge) clears all partial sums and the fill count, and drives `outValid` low and `outData` to zero. The kernel already loaded is kept and is used for the samples that follow the reset.
- R7: `outData` is ceil(log2(KLEN+1)) bits wide. A valid result never exceeds KLEN, and it reaches KLEN when both the kernel and the window are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; the kernel is kept |
| kernLoad | input | 1 | Kernel load strobe: shifts `kernBit` in and blocks the input stream |
| kernBit | input | 1 | Kernel bit being loaded |
| inVal | input | 1 | Input sample valid |
| inBit | input | 1 | Input sample (1 = inside, 0 = outside) |
| outValid | output | 1 | Result valid, one cycle per accepted sample once the window is full |
| outData | output | ceil(log2(KLEN+1)) | Correlation result |

## Verification
The bench builds the block with `KLEN = 7`, which gives a 3-bit result. With all-ones operands the sum lands exactly on the largest code, 7, so any carry lost at the top of the chain shows up. The short window also makes fill restarts after reset and after reload cheap to exercise many times. A pause in the middle of a stream, a reload while samples are still offered, and a reset that keeps the kernel are all compared against a window model built from the requirements.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic kernShift;  // shift one kernel bit into the tap register
    logic advance;    // broadcast an accepted sample down the chain
    logic clear;      // zero every partial sum
  } corrCtl_t;

endpackage

// File: rtl/corr_pe.sv
module corr_pe #(
  parameter int ACCW = 4
) (
  input  logic            clk,
  input  logic            clear,
  input  logic            advance,
  input  logic            kernTap,
  input  logic            sample,
  input  logic [ACCW-1:0] sumIn,
  output logic [ACCW-1:0] sumOut
);

  // A 1-bit product is just an AND
  logic product;

  always_comb product = kernTap & sample;

  always_ff @(posedge clk) begin
    if (clear) begin
      sumOut <= '0;
    end else if (advance) begin
      sumOut <= sumIn + ACCW'(product);
    end
  end

endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int KLEN = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     kernLoad,
  input  logic     inVal,
  output corrCtl_t ctl,
  output logic     outValid
);

  localparam int CNTW = (KLEN > 2) ? $clog2(KLEN) : 1;
  localparam logic [CNTW-1:0] FULL = CNTW'(KLEN - 1);

  // Number of accepted samples since the last clear, saturating at KLEN-1
  logic [CNTW-1:0] fillCnt;

  always_comb begin
    ctl.kernShift = kernLoad;
    ctl.advance   = inVal & ~kernLoad & ~rst;
    ctl.clear     = rst | kernLoad;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      fillCnt <= '0;
    end else if (ctl.advance && (fillCnt != FULL)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.advance && (fillCnt == FULL);
    end
  end

endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int KLEN = 16,
  parameter int ACCW = 5
) (
  input  logic            clk,
  input  corrCtl_t        ctl,
  input  logic            kernBit,
  input  logic            inBit,
  output logic [ACCW-1:0] outData
);

  // tap[0] holds the most recently loaded bit; tap[KLEN-1] the first one
  logic [KLEN-1:0] tap;
  logic [ACCW-1:0] partial [KLEN];
  logic [ACCW-1:0] upstream [KLEN];

  // Kernel is deliberately not reset: it survives a stream reset
  always_ff @(posedge clk) begin
    if (ctl.kernShift) begin
      tap <= {tap[KLEN-2:0], kernBit};
    end
  end

  for (genvar g = 0; g < KLEN; g++) begin : gPe
    if (g == 0) begin : gHead
      assign upstream[g] = '0;
    end else begin : gLink
      assign upstream[g] = partial[g-1];
    end

    corr_pe #(.ACCW(ACCW)) uPe (
      .clk     (clk),
      .clear   (ctl.clear),
      .advance (ctl.advance),
      .kernTap (tap[g]),
      .sample  (inBit),
      .sumIn   (upstream[g]),
      .sumOut  (partial[g])
    );
  end

  assign outData = partial[KLEN-1];

endmodule

// File: rtl/binary_systolic_correlator.sv
module binary_systolic_correlator
  import corr_pkg::*;
#(
  parameter  int KLEN = 16,
  localparam int ACCW = $clog2(KLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kernLoad,
  input  logic            kernBit,
  input  logic            inVal,
  input  logic            inBit,
  output logic            outValid,
  output logic [ACCW-1:0] outData
);

  corrCtl_t ctl;

  corr_ctrl #(.KLEN(KLEN)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .kernLoad (kernLoad),
    .inVal    (inVal),
    .ctl      (ctl),
    .outValid (outValid)
  );

  corr_datapath #(.KLEN(KLEN), .ACCW(ACCW)) uDp (
    .clk     (clk),
    .ctl     (ctl),
    .kernBit (kernBit),
    .inBit   (inBit),
    .outData (outData)
  );

endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int KLEN = 16,
  parameter int ACCW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            kernLoad,
  input logic            inVal,
  input logic            outValid,
  input logic [ACCW-1:0] outData
);

  localparam logic [ACCW-1:0] MAXSUM = ACCW'(KLEN);

  // Independent count of accepted samples since the last clear
  logic [ACCW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || kernLoad) begin
      seen <= '0;
    end else if (inVal && seen != MAXSUM) begin
      seen <= seen + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0)); // R6

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kernLoad |=> (!outValid && outData == '0)); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!inVal && !kernLoad) |=> (!outValid && $stable(outData))); // R4

  AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inVal && !kernLoad)); // R2

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (seen == MAXSUM)); // R3

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData <= MAXSUM)); // R7

endmodule

bind binary_systolic_correlator corr_checker #(.KLEN(KLEN), .ACCW(ACCW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .kernLoad (kernLoad),
  .inVal    (inVal),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/sim_binary_systolic_correlator.sv
`timescale 1ns/1ps
module sim_binary_systolic_correlator;

  localparam int KLEN = 7;
  localparam int ACCW = $clog2(KLEN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kernLoad = 1'b0;
  logic kernBit = 1'b0;
  logic inVal = 1'b0;
  logic inBit = 1'b0;
  logic outValid;
  logic [ACCW-1:0] outData;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [KLEN-1:0] kb;   // kb[i] = i-th loaded kernel bit
  int hist[$];           // accepted samples since the last clear, newest at the back
  int expQ[$];           // expected results, in order
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  binary_systolic_correlator #(.KLEN(KLEN)) u0 (
    .clk(clk), .rst(rst), .kernLoad(kernLoad), .kernBit(kernBit),
    .inVal(inVal), .inBit(inBit), .outValid(outValid), .outData(outData)
  );

  function automatic int windowSum();
    int s = 0;
    for (int i = 0; i < KLEN; i++) begin
      s += (kb[i] && hist[KLEN-1-i] != 0) ? 1 : 0;
    end
    return s;
  endfunction

  // Monitor: pops and compares every result the design produces
  always @(negedge clk) begin
    if (outValid === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R3 or R5: result %0d during fill, expected no output", outData);
      end else begin
        int e;
        e = expQ.pop_front();
        if (int'(outData) != e) begin
          errors++;
          $display("FAIL R1: outData %0d expected %0d", outData, e);
        end
      end
    end
  end

  task automatic sendBit(input logic b);
    @(posedge clk); #2;
    rst = 1'b0; kernLoad = 1'b0; inVal = 1'b1; inBit = b;
    hist.push_back(b ? 1 : 0);
    if (hist.size() > KLEN) void'(hist.pop_front());
    if (hist.size() == KLEN) expQ.push_back(windowSum());
  endtask

  task automatic sendLfsr(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit(lfsr[0]);
    end
  endtask

  task automatic idle();
    @(posedge clk); #2;
    inVal = 1'b0; kernLoad = 1'b0;
  endtask

  // Samples are offered during the load; they must be ignored (R5)
  task automatic loadKernel(input logic [KLEN-1:0] pat);
    hist.delete();
    for (int i = 0; i < KLEN; i++) begin
      @(posedge clk); #2;
      kernLoad = 1'b1; kernBit = pat[i]; inVal = 1'b1; inBit = 1'b1;
    end
    kb = pat;
  endtask

  task automatic doReset(input string tag);
    @(posedge clk); #2;
    rst = 1'b1; inVal = 1'b0; kernLoad = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      errors++;
      $display("FAIL %s: outValid %b outData %0d expected 0 and 0", tag, outValid, outData);
    end
    hist.delete();
    expQ.delete();
  endtask

  task automatic stall(input int n);
    logic [ACCW-1:0] held;
    @(posedge clk); #2;
    inVal = 1'b0;
    @(posedge clk);
    @(negedge clk);
    held = outData;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || outData !== held) begin
        errors++;
        $display("FAIL R4: outValid %b outData %0d expected 0 and %0d", outValid, outData, held);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      errors++;
      $display("FAIL R6: reset state outValid %b outData %0d expected 0 and 0", outValid, outData);
    end
    // R1 / R2 / R3: arbitrary kernel, pseudo-random stream
    loadKernel(7'b1001101);
    sendLfsr(30);
    // R4: pause in the middle of the stream, then continue the same window
    stall(3);
    sendLfsr(12);
    stall(2);
    sendLfsr(8);
    // R7: all ones reaches the largest code
    loadKernel(7'b1111111);
    for (int i = 0; i < 12; i++) sendBit(1'b1);
    idle();
    // R6: reset in the middle of a fill, kernel kept afterwards
    loadKernel(7'b0110011);
    sendLfsr(4);
    doReset("R6");
    sendLfsr(14);
    // R5: reload while samples are offered, alternating patterns
    loadKernel(7'b1010101);
    for (int i = 0; i < 16; i++) sendBit(i[0]);
    sendLfsr(10);
    loadKernel(7'b0000000);
    sendLfsr(10);
    loadKernel(7'b1100000);
    sendLfsr(20);
    idle();
    repeat (4) @(negedge clk);
    // R2: every expected result was produced
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule